// File: doc/BRIEF.md
# Raster Window and Decimation Selector

This block sits in a camera pixel pipeline after the sensor readout. It receives a full 640x480 raster one pixel per cycle. Each pixel comes with a valid strobe, frame-start and line-start markers, and its 1-based column and row. From that stream it passes on only the pixels that belong to the picture size chosen by a size/zoom mode. The block holds no frame buffer: it forwards or drops each pixel as it arrives.

Five size selections are supported:
- full 640x480 passthrough;
- 320x240 by keeping every second pixel and line;
- 320x240 by cutting out the centred 320x240 rectangle;
- 160x120 by keeping every fourth pixel and line;
- 160x120 by keeping every second pixel and line of a centred 320x240 rectangle.

Two independent flip bits mirror the coordinates used for selection. Under a flip, the window and phase tests look at (641-x) and/or (481-y) instead of x and y.

The output is the kept pixel data with a valid flag, one cycle after the input. The output also carries regenerated line-start and frame-start markers, and these fall on the first kept pixel of a line and of a frame. The mode and flip bits are taken at the first valid pixel of each frame, so a frame is never split between two selections.

Top module: `image_winsel`

## Requirements
- R1: While reset is high, and in the first cycle after it, out_valid, out_sol and out_sof are low.
- R2: Mode code 0 forwards every valid input pixel. out_data equals the input data one clock after the input, with out_valid high.
- R3: Mode code 1 keeps the pixels with odd column 1..639 and odd row 1..479, which gives 320 per kept line.
- R4: Mode code 2 keeps every pixel with column 161..480 and row 121..360.
- R5: Mode code 3 keeps the pixels whose column is 1..637 with column mod 4 = 1, and whose row is 1..477 with row mod 4 = 1.
- R6: Mode code 4 keeps the pixels with odd column 161..479 and odd row 121..359.
- R7: Mode codes 5, 6 and 7 behave exactly as code 0.
- R8: With the horizontal flip bit set, the column test of R2 to R7 is applied to 641 minus the column.
- R9: With the vertical flip bit set, the row test is applied to 481 minus the row, independent of the horizontal flip.
- R10: out_sol is high only with out_valid, on the first kept pixel after an input line or frame start. Lines with no kept pixel produce no out_sol.
- R11: out_sof is high on the first kept pixel after an input frame start, and only there.
- R12: Mode and flip bits are sampled only on a valid pixel that carries the frame-start marker. A change during a frame takes effect at the next frame.
- R13: A cycle with in_valid low produces no output pixel in the next cycle, and its markers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Size/zoom selection code |
| cfg_hflip | input | 1 | Mirror columns for selection |
| cfg_vflip | input | 1 | Mirror rows for selection |
| in_valid | input | 1 | Input pixel present |
| in_sof | input | 1 | Input pixel is the first of a frame |
| in_sol | input | 1 | Input pixel is the first of a line |
| in_x | input | XW | Input column, 1-based |
| in_y | input | YW | Input row, 1-based |
| in_data | input | DW | Input pixel data |
| out_valid | output | 1 | Output pixel is a kept pixel |
| out_sof | output | 1 | First kept pixel of the frame |
| out_sol | output | 1 | First kept pixel of the line |
| out_data | output | DW | Output pixel data |

## Verification
Each mode is driven with whole 640-pixel lines taken from rows at the edges of every window: the first rows, the rows around 121 and 360, and the last rows. Each frame has an idle cycle between lines that carries stray markers. The kept-pixel totals tell the decimation factors apart, and the per-pixel comparison tells apart the odd/even phase and the crop edges. Flipped runs select the same number of pixels, so only the per-pixel comparison shows whether the mirrored coordinates are the ones used. A frame whose mode is changed halfway, followed by a frame in the new mode, shows that the sampling happens at frame start.

// File: rtl/winsel_pkg.sv
package winsel_pkg;

    typedef enum logic [2:0] {
        SZ_FULL     = 3'd0,
        SZ_HALF     = 3'd1,
        SZ_HALF_ZM  = 3'd2,
        SZ_QUART    = 3'd3,
        SZ_QUART_ZM = 3'd4
    } size_mode_e;

    // one axis of a source rectangle plus its decimation step (as a power of two)
    typedef struct packed {
        logic [15:0] lo;
        logic [15:0] hi;
        logic [1:0]  step_log2;
    } axis_win_t;

    typedef struct packed {
        logic       flip_h;
        logic       flip_v;
        logic [2:0] mode;
    } sel_cfg_t;

    localparam sel_cfg_t CFG_RESET = '{flip_h: 1'b0, flip_v: 1'b0, mode: 3'd0};

    // rectangle and step for one axis of extent ext (640 or 480)
    function automatic axis_win_t axis_window(input logic [2:0] mode, input int ext);
        axis_win_t w;
        case (mode)
            SZ_HALF: begin
                w.lo = 16'd1;
                w.hi = 16'(ext - 1);
                w.step_log2 = 2'd1;
            end
            SZ_HALF_ZM: begin
                w.lo = 16'(ext / 4 + 1);
                w.hi = 16'((3 * ext) / 4);
                w.step_log2 = 2'd0;
            end
            SZ_QUART: begin
                w.lo = 16'd1;
                w.hi = 16'(ext - 3);
                w.step_log2 = 2'd2;
            end
            SZ_QUART_ZM: begin
                w.lo = 16'(ext / 4 + 1);
                w.hi = 16'((3 * ext) / 4 - 1);
                w.step_log2 = 2'd1;
            end
            default: begin
                w.lo = 16'd1;
                w.hi = 16'(ext);
                w.step_log2 = 2'd0;
            end
        endcase
        return w;
    endfunction

endpackage

// File: rtl/winsel_cfg_hold.sv
module winsel_cfg_hold
    import winsel_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  sel_cfg_t cfg_in,
    output sel_cfg_t cfg_eff
);
    sel_cfg_t cfg_act;

    // the frame's first pixel already uses the newly sampled selection
    assign cfg_eff = start ? cfg_in : cfg_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_act <= CFG_RESET;
        end else if (start) begin
            cfg_act <= cfg_in;
        end
    end
endmodule

// File: rtl/winsel_axis.sv
module winsel_axis
    import winsel_pkg::*;
#(
    parameter int CW  = 10,
    parameter int EXT = 640
) (
    input  logic [CW-1:0] coord,
    input  logic          flip,
    input  axis_win_t     win,
    output logic          keep
);
    localparam logic [15:0] MIRROR_BASE = 16'(EXT + 1);

    logic [15:0] c_ext;
    logic [15:0] c_sel;
    logic [15:0] c_off;
    logic [15:0] step_mask;
    logic        in_range;
    logic        on_phase;

    always_comb begin
        c_ext     = 16'(coord);
        c_sel     = flip ? (MIRROR_BASE - c_ext) : c_ext;
        c_off     = c_sel - win.lo;
        step_mask = (16'd1 << win.step_log2) - 16'd1;
        in_range  = (c_sel >= win.lo) && (c_sel <= win.hi);
        on_phase  = (c_off & step_mask) == 16'd0;
        keep      = in_range && on_phase;
    end
endmodule

// File: rtl/winsel_marker.sv
module winsel_marker #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_sol,
    input  logic          keep,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic          out_sof,
    output logic          out_sol,
    output logic [DW-1:0] out_data
);
    logic frame_start;
    logic line_start;
    logic line_hit;
    logic frame_hit;
    logic first_in_line;
    logic first_in_frame;

    always_comb begin
        frame_start    = in_valid && in_sof;
        line_start     = in_valid && (in_sol || in_sof);
        first_in_line  = keep && (line_start || !line_hit);
        first_in_frame = keep && (frame_start || !frame_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_hit  <= 1'b1;
            frame_hit <= 1'b1;
        end else begin
            if (line_start) begin
                line_hit <= keep;
            end else if (keep) begin
                line_hit <= 1'b1;
            end
            if (frame_start) begin
                frame_hit <= keep;
            end else if (keep) begin
                frame_hit <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_sol   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= keep;
            out_sof   <= first_in_frame;
            out_sol   <= first_in_line;
            if (keep) begin
                out_data <= in_data;
            end
        end
    end
endmodule

// File: rtl/image_winsel.sv
module image_winsel
    import winsel_pkg::*;
#(
    parameter int FRAME_W = 640,
    parameter int FRAME_H = 480,
    parameter int XW      = 10,
    parameter int YW      = 9,
    parameter int DW      = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    cfg_mode,
    input  logic          cfg_hflip,
    input  logic          cfg_vflip,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_sol,
    input  logic [XW-1:0] in_x,
    input  logic [YW-1:0] in_y,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic          out_sof,
    output logic          out_sol,
    output logic [DW-1:0] out_data
);
    localparam int NAXES = 2;

    sel_cfg_t  cfg_req;
    sel_cfg_t  cfg_eff;
    axis_win_t win_x;
    axis_win_t win_y;
    logic [NAXES-1:0] axis_keep;
    logic frame_start;
    logic keep;

    assign cfg_req     = '{flip_h: cfg_hflip, flip_v: cfg_vflip, mode: cfg_mode};
    assign frame_start = in_valid && in_sof;

    winsel_cfg_hold u_cfg (
        .clk     (clk),
        .rst     (rst),
        .start   (frame_start),
        .cfg_in  (cfg_req),
        .cfg_eff (cfg_eff)
    );

    assign win_x = axis_window(cfg_eff.mode, FRAME_W);
    assign win_y = axis_window(cfg_eff.mode, FRAME_H);

    winsel_axis #(.CW(XW), .EXT(FRAME_W)) u_axis_x (
        .coord (in_x),
        .flip  (cfg_eff.flip_h),
        .win   (win_x),
        .keep  (axis_keep[0])
    );

    winsel_axis #(.CW(YW), .EXT(FRAME_H)) u_axis_y (
        .coord (in_y),
        .flip  (cfg_eff.flip_v),
        .win   (win_y),
        .keep  (axis_keep[1])
    );

    assign keep = in_valid && (&axis_keep);

    winsel_marker #(.DW(DW)) u_marker (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_sol    (in_sol),
        .keep      (keep),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_sol   (out_sol),
        .out_data  (out_data)
    );
endmodule

// File: rtl/winsel_chk.sv
module winsel_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [DW-1:0] in_data,
    input logic          out_valid,
    input logic          out_sof,
    input logic          out_sol,
    input logic [DW-1:0] out_data
);
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !out_sol && !out_sof));

    a_r13_no_output_without_input: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid) |-> !out_valid);

    a_r2_data_one_cycle: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_data == $past(in_data)));

    a_r10_sol_qualified: assert property (@(posedge clk) disable iff (rst)
        out_sol |-> out_valid);

    a_r11_sof_opens_line: assert property (@(posedge clk) disable iff (rst)
        out_sof |-> out_sol);
endmodule

module winsel_cfg_chk
    import winsel_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input logic     start,
    input sel_cfg_t cfg_act
);
    a_r12_cfg_frozen_in_frame: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(cfg_act));
endmodule

bind image_winsel winsel_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_sol   (out_sol),
    .out_data  (out_data)
);

bind winsel_cfg_hold winsel_cfg_chk u_cfg_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .cfg_act (cfg_act)
);

// File: tb/image_winsel_tb.sv
module image_winsel_tb;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic [2:0]    cfg_mode;
    logic          cfg_hflip;
    logic          cfg_vflip;
    logic          in_valid;
    logic          in_sof;
    logic          in_sol;
    logic [9:0]    in_x;
    logic [8:0]    in_y;
    logic [DW-1:0] in_data;
    logic          out_valid;
    logic          out_sof;
    logic          out_sol;
    logic [DW-1:0] out_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // expected output of the previous driven cycle
    bit            ev, esol, esof;
    logic [DW-1:0] ed;
    // bench-side model state
    int  em;
    bit  ehf, evf, lhit, fhit;
    // per-frame tallies
    int  n_mis, n_kept, n_sol, n_sof, n_exp_kept, n_exp_sol;
    string first_mis;

    always #2.5 clk = ~clk;

    image_winsel u_dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_hflip(cfg_hflip),
        .cfg_vflip(cfg_vflip), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .in_x(in_x), .in_y(in_y), .in_data(in_data),
        .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
        .out_data(out_data)
    );

    function automatic bit ref_keep(int m, bit hf, bit vf, int x, int y);
        int xm = hf ? 641 - x : x;
        int ym = vf ? 481 - y : y;
        case (m)
            1: return xm <= 639 && xm % 2 == 1 && ym <= 479 && ym % 2 == 1;
            2: return xm >= 161 && xm <= 480 && ym >= 121 && ym <= 360;
            3: return xm <= 637 && xm % 4 == 1 && ym <= 477 && ym % 4 == 1;
            4: return xm >= 161 && xm <= 479 && xm % 2 == 1 &&
                      ym >= 121 && ym <= 359 && ym % 2 == 1;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [DW-1:0] pix(int x, int y);
        return DW'(x ^ (y << 6));
    endfunction

    task automatic check(string req, bit ok, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // compare outputs of the previous cycle, then drive a new one
    task automatic step(bit v, bit sf, bit sl, int x, int y);
        bit k, nl, st;
        @(negedge clk);
        if (out_valid !== ev || (ev && (out_data !== ed || out_sol !== esol || out_sof !== esof))
            || (!ev && (out_sol !== 1'b0 || out_sof !== 1'b0))) begin
            if (n_mis == 0)
                first_mis = $sformatf("x=%0d y=%0d v=%0b/%0b sol=%0b/%0b sof=%0b/%0b",
                    in_x, in_y, out_valid, ev, out_sol, esol, out_sof, esof);
            n_mis++;
        end
        if (out_valid === 1'b1) n_kept++;
        if (out_valid === 1'b1 && out_sol === 1'b1) n_sol++;
        if (out_sof === 1'b1) n_sof++;
        in_valid = v; in_sof = sf; in_sol = sl;
        in_x = 10'(x); in_y = 9'(y); in_data = pix(x, y);
        st = v && sf;
        if (st) begin
            em = int'(cfg_mode); ehf = cfg_hflip; evf = cfg_vflip;
        end
        k  = v && ref_keep(em, ehf, evf, x, y);
        nl = v && (sl || sf);
        esol = k && (nl || !lhit);
        esof = k && (st || !fhit);
        if (esol) n_exp_sol++;
        if (k) n_exp_kept++;
        if (nl) lhit = k; else if (k) lhit = 1'b1;
        if (st) fhit = k; else if (k) fhit = 1'b1;
        ev = k;
        ed = pix(x, y);
    endtask

    // rows at the edges of every window; the set maps onto itself under 481-y
    task automatic run_frame(int mode, bit hf, bit vf, int chg_line, int chg_mode,
                             int exp_kept, string req);
        int ys[8] = '{1, 2, 121, 122, 359, 360, 479, 480};
        n_mis = 0; n_kept = 0; n_sol = 0; n_sof = 0;
        n_exp_kept = 0; n_exp_sol = 0; first_mis = "";
        cfg_mode = 3'(mode); cfg_hflip = hf; cfg_vflip = vf;
        foreach (ys[li]) begin
            if (li == chg_line) cfg_mode = 3'(chg_mode);
            for (int x = 1; x <= 640; x++)
                step(1'b1, li == 0 && x == 1, x == 1, x, ys[li]);
            // idle cycle with stray markers: must be ignored (R13)
            step(1'b0, 1'b1, 1'b1, 161, 121);
        end
        step(1'b0, 1'b0, 1'b0, 0, 0);
        check({req, " per-pixel selection ", first_mis}, n_mis == 0, n_mis, 0);
        check({req, " kept total"}, n_kept == exp_kept && n_exp_kept == exp_kept, n_kept, exp_kept);
        check({req, " R10 line markers"}, n_sol == n_exp_sol, n_sol, n_exp_sol);
        check({req, " R11 frame marker count"}, n_sof == 1, n_sof, 1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        cfg_mode = 3'd0; cfg_hflip = 1'b0; cfg_vflip = 1'b0;
        in_valid = 1'b1; in_sof = 1'b1; in_sol = 1'b1;
        in_x = 10'd1; in_y = 9'd1; in_data = '1;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", out_valid === 1'b0, out_valid, 0);
        check("R1 markers in reset", out_sol === 1'b0 && out_sof === 1'b0, {out_sol, out_sof}, 0);
        in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", out_valid === 1'b0, out_valid, 0);
        ev = 0; esol = 0; esof = 0; ed = '0;
        em = 0; ehf = 0; evf = 0; lhit = 1; fhit = 1;
    endtask

    task automatic t_full();       run_frame(0, 0, 0, -1, 0, 5120, "R2 full R13");       endtask
    task automatic t_half();       run_frame(1, 0, 0, -1, 0, 1280, "R3 half");           endtask
    task automatic t_half_zoom();  run_frame(2, 0, 0, -1, 0, 1280, "R4 half zoom");      endtask
    task automatic t_quart();      run_frame(3, 0, 0, -1, 0, 320,  "R5 quarter");        endtask
    task automatic t_quart_zoom(); run_frame(4, 0, 0, -1, 0, 320,  "R6 quarter zoom");   endtask
    task automatic t_spare_code(); run_frame(6, 0, 0, -1, 0, 5120, "R7 code 6");         endtask
    task automatic t_hflip();      run_frame(1, 1, 0, -1, 0, 1280, "R8 hflip half");     endtask
    task automatic t_vflip();      run_frame(4, 0, 1, -1, 0, 320,  "R9 vflip qzoom");    endtask
    task automatic t_both_flip();  run_frame(3, 1, 1, -1, 0, 320,  "R8 R9 both flips");  endtask
    task automatic t_mid_change();
        run_frame(1, 0, 0, 3, 2, 1280, "R12 change mid-frame");
        run_frame(2, 0, 0, -1, 0, 1280, "R12 next frame");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_full();
        t_half();
        t_half_zoom();
        t_quart();
        t_quart_zoom();
        t_spare_code();
        t_hflip();
        t_vflip();
        t_both_flip();
        t_mid_change();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule